// File: doc/BRIEF.md
# Packet Control-Flow Flag Generator

This block condenses an already decoded instruction packet of up to `N_ENT` entries into a handful of packet-level flags. Those flags tell later pipeline stages whether the packet redirects the program counter, whether it does so more than once, whether it closes a hardware loop, which memory slots hold a real scalar store, and whether it contains a cache-line zero allocation. Decoding opcodes into class bits happens upstream. Each entry arrives here as one bit per class plus a two-bit slot number.

The entries are folded in index order, from 0 upward. Only the first `count` entries take part. An entry flagged as the compare half of a split compare-and-jump is skipped. A loop end is treated as a change of flow. From the entry holding the first loop end onward, every entry that takes part asserts change of flow again, so the multiple flag rises whenever something has already redirected the flow. The summary is captured on `in_vld` and held until the next strobe. It can also be taken straight from the combinational fold by clearing `REG_OUT`.

Top module: `pkt_flow_flags`

## Requirements
- R1: While reset is held and on the first cycle after it, every output is 0.
- R2: An entry takes part only if its index is below `count` and its compare-half bit is 0. An entry that does not take part affects no flag and has its `entry_endloop` bit at 0. A packet with `count` = 0 produces all-zero flags.
- R3: A taking-part entry with any of the jump, call, trap or pause bits set is a flow candidate. An entry with the hint-jump-register bit set is never a candidate, whatever its other bits are. Any candidate sets `cof`.
- R4: A second flow candidate in the same packet sets `multi_cof`.
- R5: `entry_endloop[i]` is the OR of the loop-0-end and loop-1-end bits of taking-part entry i. `has_endloop` is the OR of all the `entry_endloop` bits.
- R6: Once a taking-part entry with a loop end has been reached, that entry and every later taking-part entry set `cof`. Each of them also sets `multi_cof` if `cof` was already set by an earlier step. So a loop end on a jump entry, or a loop end followed by any taking-part entry, yields `multi_cof`. A lone loop end on the last taking-part entry yields `cof` without `multi_cof`.
- R7: A taking-part entry with store = 1, scalar-store = 1 and zero-size = 0 sets `store_s0` if its slot field (`slot_flat[2i+1:2i]`) is 0, and sets `store_s1` for any other slot value. A store that fails any of these three conditions sets neither.
- R8: `cache_zero` is set if any taking-part entry has its cache-zero bit set.
- R9: With `REG_OUT` = 1, the flags are captured on the clock edge where `in_vld` = 1 and appear one cycle later, with `out_vld` high for that one cycle. While `in_vld` = 0 the flags hold their value, whatever the entry inputs do.
- R10: `multi_cof` is never 1 while `cof` is 0, and `has_endloop` is never 1 while `cof` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Packet present; capture strobe |
| count | input | CW | Number of entries that take part (CW = clog2(N_ENT+1)) |
| is_jump | input | N_ENT | Per-entry jump class bit |
| is_call | input | N_ENT | Per-entry call class bit |
| is_trap | input | N_ENT | Per-entry trap class bit |
| is_pause | input | N_ENT | Per-entry pause class bit |
| is_hintjr | input | N_ENT | Per-entry hint-jump-register class bit |
| is_lp0end | input | N_ENT | Per-entry loop-0 end bit |
| is_lp1end | input | N_ENT | Per-entry loop-1 end bit |
| is_store | input | N_ENT | Per-entry store class bit |
| is_scalar_st | input | N_ENT | Per-entry scalar-store bit |
| is_zero_size | input | N_ENT | Per-entry zero-size memory access bit |
| is_czero | input | N_ENT | Per-entry cache-zero allocate bit |
| is_cmp_half | input | N_ENT | Per-entry compare-half marker |
| slot_flat | input | 2*N_ENT | Slot of entry i in bits [2i+1:2i] |
| out_vld | output | 1 | Flags updated this cycle |
| cof | output | 1 | Packet changes flow |
| multi_cof | output | 1 | Packet changes flow more than once |
| has_endloop | output | 1 | Packet ends a hardware loop |
| store_s0 | output | 1 | Scalar store in slot 0 |
| store_s1 | output | 1 | Scalar store in another slot |
| cache_zero | output | 1 | Packet holds a cache-zero allocation |
| entry_endloop | output | N_ENT | Per-entry loop-end marker |

## Verification
Two functions can land on the same step of the fold: the jump-candidate update and the loop-end update. They share the `cof`/`multi_cof` pair, so their order decides the result. Directed packets put a jump bit on the same entry as a loop end, put a loop end first and follow it with a plain entry, and hide a loop end behind a compare-half marker or beyond `count`. The random packets set the class bits sparsely so that these collisions recur. Every packet is judged against a bench function that folds the requirements in index order.

// File: rtl/pkt_flow_pkg.sv
package pkt_flow_pkg;
  localparam int SLOT_W = 2;

  typedef struct packed {
    logic cof;
    logic multi_cof;
    logic has_endloop;
    logic store_s0;
    logic store_s1;
    logic cache_zero;
  } pkt_flags_t;
endpackage

// File: rtl/pkt_rst_sync.sv
module pkt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/pkt_entry_class.sv
module pkt_entry_class #(
  parameter int IDX = 0,
  parameter int CW  = 4
) (
  input  logic [CW-1:0] count,
  input  logic          jump,
  input  logic          call,
  input  logic          trap,
  input  logic          pause,
  input  logic          hintjr,
  input  logic          lp0end,
  input  logic          lp1end,
  input  logic          store,
  input  logic          scalar_st,
  input  logic          zero_size,
  input  logic          czero,
  input  logic          cmp_half,
  input  logic [1:0]    slot,
  output logic          active,
  output logic          flow_cand,
  output logic          endl,
  output logic          st0,
  output logic          st1,
  output logic          cz
);
  localparam logic [CW-1:0] IDX_C = CW'(IDX);

  logic real_store;

  always_comb begin
    active     = (IDX_C < count) && !cmp_half;
    flow_cand  = active && (jump || call || trap || pause) && !hintjr;
    endl       = active && (lp0end || lp1end);
    real_store = active && store && scalar_st && !zero_size;
    st0        = real_store && (slot == 2'd0);
    st1        = real_store && (slot != 2'd0);
    cz         = active && czero;
  end
endmodule

// File: rtl/pkt_flow_fold.sv
module pkt_flow_fold
  import pkt_flow_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic [N_ENT-1:0] active,
  input  logic [N_ENT-1:0] flow_cand,
  input  logic [N_ENT-1:0] endl,
  input  logic [N_ENT-1:0] st0,
  input  logic [N_ENT-1:0] st1,
  input  logic [N_ENT-1:0] cz,
  output pkt_flags_t       flags
);
  logic cof_acc, multi_acc, seen_acc;

  always_comb begin
    cof_acc   = 1'b0;
    multi_acc = 1'b0;
    seen_acc  = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (active[i]) begin
        if (flow_cand[i]) begin
          if (cof_acc) multi_acc = 1'b1;
          cof_acc = 1'b1;
        end
        seen_acc = seen_acc | endl[i];
        if (seen_acc) begin
          if (cof_acc) multi_acc = 1'b1;
          cof_acc = 1'b1;
        end
      end
    end
    flags.cof         = cof_acc;
    flags.multi_cof   = multi_acc;
    flags.has_endloop = seen_acc;
    flags.store_s0    = |st0;
    flags.store_s1    = |st1;
    flags.cache_zero  = |cz;
  end
endmodule

// File: rtl/pkt_flow_flags.sv
module pkt_flow_flags
  import pkt_flow_pkg::*;
#(
  parameter int N_ENT   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int CW     = $clog2(N_ENT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic [CW-1:0]            count,
  input  logic [N_ENT-1:0]         is_jump,
  input  logic [N_ENT-1:0]         is_call,
  input  logic [N_ENT-1:0]         is_trap,
  input  logic [N_ENT-1:0]         is_pause,
  input  logic [N_ENT-1:0]         is_hintjr,
  input  logic [N_ENT-1:0]         is_lp0end,
  input  logic [N_ENT-1:0]         is_lp1end,
  input  logic [N_ENT-1:0]         is_store,
  input  logic [N_ENT-1:0]         is_scalar_st,
  input  logic [N_ENT-1:0]         is_zero_size,
  input  logic [N_ENT-1:0]         is_czero,
  input  logic [N_ENT-1:0]         is_cmp_half,
  input  logic [SLOT_W*N_ENT-1:0]  slot_flat,
  output logic                     out_vld,
  output logic                     cof,
  output logic                     multi_cof,
  output logic                     has_endloop,
  output logic                     store_s0,
  output logic                     store_s1,
  output logic                     cache_zero,
  output logic [N_ENT-1:0]         entry_endloop
);
  logic [N_ENT-1:0] act_w, cand_w, endl_w, st0_w, st1_w, cz_w;
  pkt_flags_t       fold_w;

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
    pkt_entry_class #(.IDX(gi), .CW(CW)) u_cls (
      .count     (count),
      .jump      (is_jump[gi]),
      .call      (is_call[gi]),
      .trap      (is_trap[gi]),
      .pause     (is_pause[gi]),
      .hintjr    (is_hintjr[gi]),
      .lp0end    (is_lp0end[gi]),
      .lp1end    (is_lp1end[gi]),
      .store     (is_store[gi]),
      .scalar_st (is_scalar_st[gi]),
      .zero_size (is_zero_size[gi]),
      .czero     (is_czero[gi]),
      .cmp_half  (is_cmp_half[gi]),
      .slot      (slot_flat[gi*SLOT_W +: SLOT_W]),
      .active    (act_w[gi]),
      .flow_cand (cand_w[gi]),
      .endl      (endl_w[gi]),
      .st0       (st0_w[gi]),
      .st1       (st1_w[gi]),
      .cz        (cz_w[gi])
    );
  end

  pkt_flow_fold #(.N_ENT(N_ENT)) u_fold (
    .active    (act_w),
    .flow_cand (cand_w),
    .endl      (endl_w),
    .st0       (st0_w),
    .st1       (st1_w),
    .cz        (cz_w),
    .flags     (fold_w)
  );

  pkt_flags_t flags_o;
  assign cof         = flags_o.cof;
  assign multi_cof   = flags_o.multi_cof;
  assign has_endloop = flags_o.has_endloop;
  assign store_s0    = flags_o.store_s0;
  assign store_s1    = flags_o.store_s1;
  assign cache_zero  = flags_o.cache_zero;

  if (REG_OUT) begin : g_reg
    logic             rst_ns;
    pkt_flags_t       flags_q, flags_d;
    logic [N_ENT-1:0] eloop_q, eloop_d;
    logic             vld_q;

    pkt_rst_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

    always_comb begin
      flags_d = flags_q;
      eloop_d = eloop_q;
      if (in_vld) begin
        flags_d = fold_w;
        eloop_d = endl_w;
      end
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) begin
        flags_q <= '0;
        eloop_q <= '0;
        vld_q   <= 1'b0;
      end else begin
        flags_q <= flags_d;
        eloop_q <= eloop_d;
        vld_q   <= in_vld;
      end
    end

    assign flags_o       = flags_q;
    assign entry_endloop = eloop_q;
    assign out_vld       = vld_q;

    // R10
    multi_needs_cof_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      multi_cof |-> cof);
    // R10
    endloop_needs_cof_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      has_endloop |-> cof);
    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      !in_vld |=> $stable({flags_o, entry_endloop}));
    // R9
    vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      in_vld |=> out_vld);
    // R2
    empty_packet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (in_vld && count == '0) |=> (flags_o == '0 && entry_endloop == '0));
  end else begin : g_comb
    assign flags_o       = fold_w;
    assign entry_endloop = endl_w;
    assign out_vld       = in_vld;
  end
endmodule

// File: tb/tb_pkt_flow_flags.sv
module tb_pkt_flow_flags;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [CW-1:0] count = '0;
  logic [N-1:0] jmp = '0, cal = '0, trp = '0, pau = '0, hjr = '0, l0 = '0, l1 = '0;
  logic [N-1:0] st = '0, sst = '0, zs = '0, czb = '0, ch = '0;
  logic [2*N-1:0] slots = '0;
  logic out_vld, cof, multi_cof, has_endloop, store_s0, store_s1, cache_zero;
  logic [N-1:0] entry_endloop;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pkt_flow_flags #(.N_ENT(N), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .count(count),
    .is_jump(jmp), .is_call(cal), .is_trap(trp), .is_pause(pau),
    .is_hintjr(hjr), .is_lp0end(l0), .is_lp1end(l1), .is_store(st),
    .is_scalar_st(sst), .is_zero_size(zs), .is_czero(czb), .is_cmp_half(ch),
    .slot_flat(slots), .out_vld(out_vld), .cof(cof), .multi_cof(multi_cof),
    .has_endloop(has_endloop), .store_s0(store_s0), .store_s1(store_s1),
    .cache_zero(cache_zero), .entry_endloop(entry_endloop)
  );

  // Reference: {cof, multi, endloop, s0, s1, cz, per-entry endloop}
  function automatic logic [6+N-1:0] ref_model();
    logic c = 0, m = 0, seen = 0, s0 = 0, s1 = 0, z = 0;
    logic [N-1:0] el = '0;
    for (int i = 0; i < N; i++) begin
      if (i < int'(count) && !ch[i]) begin
        if ((jmp[i] | cal[i] | trp[i] | pau[i]) && !hjr[i]) begin
          if (c) m = 1;
          c = 1;
        end
        el[i] = l0[i] | l1[i];
        seen  = seen | el[i];
        if (seen) begin
          if (c) m = 1;
          c = 1;
        end
        if (st[i] && sst[i] && !zs[i]) begin
          if (slots[2*i +: 2] == 2'd0) s0 = 1; else s1 = 1;
        end
        if (czb[i]) z = 1;
      end
    end
    return {c, m, seen, s0, s1, z, el};
  endfunction

  function automatic logic [6+N-1:0] got();
    return {cof, multi_cof, has_endloop, store_s0, store_s1, cache_zero, entry_endloop};
  endfunction

  task automatic check(input string req, input logic [6+N-1:0] g, input logic [6+N-1:0] e);
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, g, e);
    end
  endtask

  task automatic clear_ins();
    jmp = '0; cal = '0; trp = '0; pau = '0; hjr = '0; l0 = '0; l1 = '0;
    st = '0; sst = '0; zs = '0; czb = '0; ch = '0; slots = '0; count = CW'(N);
  endtask

  // inputs must be set before the call (they change only at negedge)
  task automatic apply(input string req);
    logic [6+N-1:0] e;
    e = ref_model();
    in_vld = 1'b1;
    @(posedge clk); #1;
    check(req, got(), e);
    checks++;
    if (out_vld !== 1'b1) begin
      errors++;
      $display("FAIL R9: out_vld got %b expected 1", out_vld);
    end
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [6+N-1:0] held;
    void'($urandom(32'h5EED_1234));
    clear_ins();
    jmp = '1; l0 = '1; st = '1; sst = '1; czb = '1;
    repeat (2) @(posedge clk); #1;
    check("R1 in reset", got(), '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", got(), '0);
    repeat (3) @(negedge clk);

    // R2: count zero, all bits set
    count = '0; apply("R2 count zero");
    // R2: everything marked compare half
    @(negedge clk); count = CW'(N); ch = '1; apply("R2 all cmp half");
    // R2: loop end beyond count ignored
    @(negedge clk); clear_ins(); count = CW'(3); l1[5] = 1; jmp[6] = 1; apply("R2 beyond count");
    // R3: hint-jump-register with jump bit never counts
    @(negedge clk); clear_ins(); jmp[2] = 1; hjr[2] = 1; apply("R3 hintjr excluded");
    @(negedge clk); clear_ins(); trp[4] = 1; apply("R3 single trap");
    // R4: two candidates
    @(negedge clk); clear_ins(); cal[1] = 1; pau[6] = 1; apply("R4 call plus pause");
    // R6: jump and loop end on one entry
    @(negedge clk); clear_ins(); jmp[0] = 1; l0[0] = 1; count = CW'(1); apply("R6 jump with endloop");
    // R6: loop end then plain entry
    @(negedge clk); clear_ins(); l0[0] = 1; count = CW'(2); apply("R6 endloop then plain");
    // R5 R6: lone loop end on last entry
    @(negedge clk); clear_ins(); l1[7] = 1; apply("R5 R6 lone endloop last");
    // R6: loop end hidden behind compare half
    @(negedge clk); clear_ins(); l0[3] = 1; ch[3] = 1; jmp[5] = 1; apply("R6 cmp half endloop");
    // R7: store slots and zero-size
    @(negedge clk); clear_ins(); st[1] = 1; sst[1] = 1; slots[3:2] = 2'd0; apply("R7 store slot0");
    @(negedge clk); clear_ins(); st[2] = 1; sst[2] = 1; slots[5:4] = 2'd3; apply("R7 store slot3");
    @(negedge clk); clear_ins(); st[2] = 1; sst[2] = 1; zs[2] = 1; st[4] = 1; apply("R7 zero size and non-scalar");
    // R8
    @(negedge clk); clear_ins(); czb[7] = 1; apply("R8 cache zero");

    // R9: hold while idle
    @(negedge clk); clear_ins(); jmp[0] = 1; cal[3] = 1; l0[5] = 1; apply("R9 load");
    held = got();
    jmp = '0; l0 = '0; cal = '0; czb = '1; count = CW'(N);
    repeat (3) @(posedge clk); #1;
    check("R9 hold", got(), held);
    checks++;
    if (out_vld !== 1'b0) begin
      errors++;
      $display("FAIL R9: out_vld got %b expected 0", out_vld);
    end

    // random mix, R2..R8 and R10 collisions
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      count = CW'($urandom_range(0, N + 2));
      jmp = N'($urandom & $urandom & $urandom);
      cal = N'($urandom & $urandom & $urandom & $urandom);
      trp = N'($urandom & $urandom & $urandom & $urandom);
      pau = N'($urandom & $urandom & $urandom & $urandom);
      hjr = N'($urandom & $urandom & $urandom);
      l0  = N'($urandom & $urandom & $urandom);
      l1  = N'($urandom & $urandom & $urandom);
      st  = N'($urandom & $urandom);
      sst = N'($urandom);
      zs  = N'($urandom & $urandom);
      czb = N'($urandom & $urandom & $urandom);
      ch  = N'($urandom & $urandom & $urandom);
      slots = (2*N)'($urandom);
      apply("R2-R8 random");
      checks++;
      if (multi_cof && !cof) begin
        errors++;
        $display("FAIL R10: multi %b cof %b expected cof 1", multi_cof, cof);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule